// File: doc/BRIEF.md
# Persistent Overhead Byte Monitor

This block watches one 8-bit overhead byte per frame on each of several SONET/SDH channels (three by default, one per STS-1/STM-1). For each channel it tracks a candidate value and counts how many consecutive frames have carried it. The candidate moves into the channel's stable register only once that count reaches a programmable persistence setting. Single-frame glitches and bit errors therefore never reach the stable value.

When the stable value changes, the old value is kept as history and a sticky change flag is raised. The flags are combined into one interrupt, and each channel has its own mask bit. The upstream framer supplies the byte strobes and a per-channel out-of-frame level. When a channel goes out of frame, its persistence count is discarded. Strobes that arrive while the channel is out of frame are ignored.

Top module: `ohb_persist_mon`

## Requirements
- R1: After reset every stable byte, history byte, change flag and the interrupt read 0.
- R2: With a persistence setting N from 1 to 15, a byte is accepted into the stable register at the clock edge that samples its Nth consecutive strobe, and not before. Channel i uses byte lane bits [8i+7:8i].
- R3: A persistence setting of 0 behaves as 1, so a byte is accepted on its first strobe.
- R4: A strobe carrying a byte different from the current candidate makes that byte the new candidate with a count of 1.
- R5: A rising edge of a channel's out-of-frame input clears that channel's count. After it, N fresh strobes are needed even if the byte is unchanged.
- R6: Strobes sampled while a channel's out-of-frame input is high change neither its count nor its stable register.
- R7: When an accepted byte differs from the stable value, the history register takes the old stable value, the stable register takes the new byte, and the channel's change flag is set.
- R8: Accepting a byte equal to the current stable value leaves the history register and the change flag untouched.
- R9: A change flag is cleared by a clear-write with a 1 in that channel's bit position. A 0 bit has no effect. A flag set in the same cycle wins over a clear.
- R10: The interrupt is high exactly when some channel has its change flag set and its mask bit at 0.
- R11: Channels are independent: strobes on one channel never alter another channel's registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld | input | NCH | Per-channel strobe, one cycle per frame |
| byte_in | input | NCH*BW | Overhead byte, channel i in lane i |
| oof | input | NCH | Per-channel out-of-frame level |
| persist_n | input | CW | Persistence setting, 0 acts as 1 |
| clr_we | input | 1 | Clear-write strobe for the change flags |
| clr_data | input | NCH | Write-one-to-clear bits, one per channel |
| irq_mask | input | NCH | Per-channel interrupt mask, 1 blocks |
| acc_byte | output | NCH*BW | Stable (accepted) byte per channel |
| prev_byte | output | NCH*BW | Previously accepted byte per channel |
| chg_flag | output | NCH | Sticky change flags |
| irq | output | 1 | Masked OR of the change flags |

## Verification
The bench uses the default build: three channels, 8-bit bytes and a 4-bit persistence setting. With a 4-bit setting, all sixteen settings can be swept on one channel. Each setting is checked for acceptance exactly at the Nth strobe, for a restart caused by an intervening different byte, and for the resulting history and flag. The other channels then cover out-of-frame edges, strobes while out of frame, re-acceptance of an unchanged value, and the mask, clear and set-over-clear behaviour of the interrupt path.

// File: rtl/ohb_persist_mon.sv
module ohb_persist_mon #(
  parameter int NCH = 3,
  parameter int BW  = 8,
  parameter int CW  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    byte_vld,
  input  logic [NCH*BW-1:0] byte_in,
  input  logic [NCH-1:0]    oof,
  input  logic [CW-1:0]     persist_n,
  input  logic              clr_we,
  input  logic [NCH-1:0]    clr_data,
  input  logic [NCH-1:0]    irq_mask,
  output logic [NCH*BW-1:0] acc_byte,
  output logic [NCH*BW-1:0] prev_byte,
  output logic [NCH-1:0]    chg_flag,
  output logic              irq
);
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0]  thr;
  logic [NCH-1:0] oof_q;

  assign thr = (persist_n == '0) ? CW'(1) : persist_n;
  assign irq = |(chg_flag & ~irq_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) oof_q <= '0;
    else        oof_q <= oof;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [BW-1:0] cand, acc, prv, b;
    logic [CW-1:0] cnt, nxt;
    logic          strobe, match, take, newval, oof_rise;

    assign b        = byte_in[i*BW +: BW];
    assign strobe   = byte_vld[i] & ~oof[i];
    assign oof_rise = oof[i] & ~oof_q[i];
    assign match    = (cnt != '0) && (b == cand);
    assign nxt      = match ? ((cnt == CMAX) ? cnt : cnt + 1'b1) : CW'(1);
    assign take     = strobe && (nxt >= thr);
    assign newval   = take && (b != acc);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cand <= '0;
        cnt  <= '0;
        acc  <= '0;
        prv  <= '0;
        chg_flag[i] <= 1'b0;
      end else begin
        if (oof_rise) cnt <= '0;
        else if (strobe) begin
          cand <= b;
          cnt  <= nxt;
        end
        if (newval) begin
          acc <= b;
          prv <= acc;
        end
        if (newval)                    chg_flag[i] <= 1'b1;
        else if (clr_we && clr_data[i]) chg_flag[i] <= 1'b0;
      end
    end

    assign acc_byte[i*BW +: BW]  = acc;
    assign prev_byte[i*BW +: BW] = prv;
  end
endmodule

module ohb_persist_mon_chk #(
  parameter int NCH = 3,
  parameter int BW  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCH-1:0]    byte_vld,
  input logic [NCH-1:0]    oof,
  input logic              clr_we,
  input logic [NCH-1:0]    clr_data,
  input logic [NCH*BW-1:0] acc_byte,
  input logic [NCH*BW-1:0] prev_byte,
  input logic [NCH-1:0]    chg_flag,
  input logic              irq
);
  for (genvar i = 0; i < NCH; i++) begin : g_a
    assert_hold_oof_R6: assert property (@(posedge clk) disable iff (!rst_n)
      oof[i] |=> $stable(acc_byte[i*BW +: BW]));
    assert_needs_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_byte[i*BW +: BW] != $past(acc_byte[i*BW +: BW])) |-> $past(byte_vld[i] && !oof[i]));
    assert_history_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_byte[i*BW +: BW] != $past(acc_byte[i*BW +: BW])) |-> (prev_byte[i*BW +: BW] == $past(acc_byte[i*BW +: BW])));
    assert_flag_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chg_flag[i]) |-> (acc_byte[i*BW +: BW] != $past(acc_byte[i*BW +: BW])));
    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && clr_data[i]) |=> (!chg_flag[i] || (acc_byte[i*BW +: BW] != $past(acc_byte[i*BW +: BW]))));
  end
  assert_irq_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (chg_flag != '0));
endmodule

bind ohb_persist_mon ohb_persist_mon_chk #(.NCH(NCH), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .oof(oof), .clr_we(clr_we),
  .clr_data(clr_data), .acc_byte(acc_byte), .prev_byte(prev_byte),
  .chg_flag(chg_flag), .irq(irq)
);

// File: tb/tb_ohb_persist_mon.sv
module tb_ohb_persist_mon;
  localparam int NCH = 3, BW = 8, CW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NCH-1:0] byte_vld = '0, oof = '0, clr_data = '0, irq_mask = '0;
  logic [NCH*BW-1:0] byte_in = '0;
  logic [CW-1:0] persist_n = '0;
  logic clr_we = 1'b0;
  logic [NCH*BW-1:0] acc_byte, prev_byte;
  logic [NCH-1:0] chg_flag;
  logic irq;
  int n_chk = 0, n_fail = 0;

  ohb_persist_mon #(.NCH(NCH), .BW(BW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in), .oof(oof),
    .persist_n(persist_n), .clr_we(clr_we), .clr_data(clr_data), .irq_mask(irq_mask),
    .acc_byte(acc_byte), .prev_byte(prev_byte), .chg_flag(chg_flag), .irq(irq)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] acc_of(input int ch);
    return acc_byte[ch*BW +: BW];
  endfunction

  function automatic logic [7:0] prev_of(input int ch);
    return prev_byte[ch*BW +: BW];
  endfunction

  task automatic strobe(input int ch, input logic [7:0] v);
    @(negedge clk);
    byte_vld[ch] = 1'b1;
    byte_in[ch*BW +: BW] = v;
    @(negedge clk);
    byte_vld = '0;
  endtask

  task automatic pulse_oof(input int ch);
    @(negedge clk) oof[ch] = 1'b1;
    @(negedge clk) oof[ch] = 1'b0;
  endtask

  task automatic clear(input logic [NCH-1:0] bits);
    @(negedge clk);
    clr_we = 1'b1;
    clr_data = bits;
    @(negedge clk);
    clr_we = 1'b0;
    clr_data = '0;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] old;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 acc", acc_byte, '0);
    chk("R1 prev", prev_byte, '0);
    chk("R1 flag", chg_flag, '0);
    chk("R1 irq", irq, 0);

    // Sweep all persistence settings on channel 0
    for (int t = 0; t < 16; t++) begin
      int e;
      logic [7:0] v, w;
      string tag;
      e = (t == 0) ? 1 : t;
      tag = (t == 0) ? "R3" : "R2";
      v = 8'h40 + 8'(t);
      w = 8'hA0 + 8'(t);
      persist_n = CW'(t);
      pulse_oof(0);
      old = acc_of(0);
      for (int k = 0; k < e - 1; k++) strobe(0, v);
      if (e > 1) chk({tag, " early"}, acc_of(0), old);
      if (e >= 2) begin
        strobe(0, w);
        for (int k = 0; k < e - 1; k++) strobe(0, v);
        chk("R4 restart", acc_of(0), old);
      end
      strobe(0, v);
      chk({tag, " accept"}, acc_of(0), v);
      chk("R7 history", prev_of(0), old);
      chk("R7 flag", chg_flag[0], 1);
      clear(3'b001);
    end
    chk("R11 ch1 untouched", acc_of(1), 0);
    chk("R11 ch2 untouched", acc_of(2), 0);

    // Out-of-frame edge clears the count
    persist_n = 4;
    repeat (3) strobe(1, 8'h11);
    pulse_oof(1);
    repeat (3) strobe(1, 8'h11);
    chk("R5 count cleared", acc_of(1), 0);
    strobe(1, 8'h11);
    chk("R5 accept after oof", acc_of(1), 8'h11);

    // Strobes ignored while out of frame
    persist_n = 1;
    @(negedge clk) oof[1] = 1'b1;
    strobe(1, 8'h22);
    strobe(1, 8'h22);
    chk("R6 ignored", acc_of(1), 8'h11);
    @(negedge clk) oof[1] = 1'b0;
    strobe(1, 8'h22);
    chk("R6 resume", acc_of(1), 8'h22);

    // Re-acceptance of the stable value
    clear('1);
    persist_n = 3;
    repeat (5) strobe(1, 8'h22);
    chk("R8 flag", chg_flag[1], 0);
    chk("R8 prev", prev_of(1), 8'h11);
    chk("R8 acc", acc_of(1), 8'h22);

    // Mask, clear and interrupt
    persist_n = 0;
    strobe(2, 8'h5A);
    chk("R7 ch2 flag", chg_flag, 3'b100);
    chk("R11 ch0 kept", acc_of(0), 8'h4F);
    @(negedge clk) irq_mask = 3'b100;
    #1 chk("R10 masked", irq, 0);
    @(negedge clk) irq_mask = 3'b011;
    #1 chk("R10 unmasked", irq, 1);
    clear(3'b011);
    chk("R9 zero bit no effect", chg_flag, 3'b100);
    clear(3'b100);
    chk("R9 cleared", chg_flag, 0);
    chk("R10 no flag", irq, 0);
    @(negedge clk);
    byte_vld[2] = 1'b1;
    byte_in[2*BW +: BW] = 8'h77;
    clr_we = 1'b1;
    clr_data = 3'b100;
    @(negedge clk);
    byte_vld = '0;
    clr_we = 1'b0;
    clr_data = '0;
    chk("R9 set wins", chg_flag[2], 1);
    chk("R7 ch2 prev", prev_of(2), 8'h5A);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule